// File: doc/BRIEF.md
# I2C Master SCL Clock Generator with Clock-Stretch Arbitration

This block produces the serial clock of an I2C master. It alternates between a low phase, in which it pulls SCL down through an open-drain output, and a high phase, in which it lets the line go. Both phases are timed by one reloadable 7-bit down-counter. The counter decrements only on cycles where a phase strobe is asserted, and it rests at zero when it gets there.

After each low phase the block releases SCL and then waits. The counter is frozen until the synchronized line is actually seen high. Only then is the counter reloaded and the high phase timed. A slave that holds SCL low therefore stretches the clock, but it can never shorten the high time the master guarantees.

The byte engine drives an enable level and reads two single-cycle pulses, one at the end of each low period and one at the end of each high period. While the enable is low the block stays idle and leaves SCL released.

Top module: `scl_clock_gen`

## Requirements
- R1: During and after reset, with `enable` low, `scl_drive_low`, `high_done` and `low_done` are all 0.
- R2: One cycle after `enable` is first sampled high, the block enters the low phase and asserts `scl_drive_low`.
- R3: With `tick` high every cycle, `scl_drive_low` stays asserted for L+1 cycles, where L is the effective count. `low_done` pulses in the first cycle in which `scl_drive_low` is deasserted.
- R4: After the low phase the block keeps SCL released and the counter frozen for as long as the synchronized `scl_in` is low. No `high_done` is produced during this time, however long the hold lasts.
- R5: With `tick` high every cycle, `scl_drive_low` is reasserted exactly L+4 cycles after `scl_in` rises. This covers two synchronizer stages, one reload cycle, L decrements and one zero-detect cycle. The time does not depend on how long the line was held low. `high_done` pulses in the cycle in which `scl_drive_low` is reasserted.
- R6: The counter decrements only in cycles where `tick` is 1. With `tick` held at 0, a phase never ends.
- R7: The effective count L equals `reload_val`, except that a `reload_val` of 0 is treated as 1.
- R8: One cycle after `enable` is sampled low, `scl_drive_low` is 0, and no done pulse is issued while disabled.
- R9: Each done pulse lasts one cycle. `high_done` and `low_done` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe; the counter decrements only when this is 1 |
| enable | input | 1 | Run request from the byte engine |
| reload_val | input | 7 | Phase length in strobe periods (0 is treated as 1) |
| scl_in | input | 1 | Raw level sampled from the SCL pin |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| high_done | output | 1 | One-cycle pulse at the end of a high period |
| low_done | output | 1 | One-cycle pulse at the end of a low period |

## Verification
The assertions check on every cycle the properties that hold locally:
- the counter stays frozen and SCL stays released while waiting for the line to go high;
- the reload happens on the first synchronized high sample;
- the counter is gated by the strobe;
- a load from idle is never zero;
- SCL is released after disable;
- the done pulses are single-cycle and exclusive.

Only the bench scenarios can show the end-to-end phase durations. These include the L+4 high time measured from the actual line rise under slave holds of different lengths, and a full phase that never ends when the strobe is withheld.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic [CW-1:0] reload_val,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          high_done,
  output logic          low_done
);

  localparam int SYNC = 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [SYNC-1:0] sync_q;
  logic            scl_seen;
  logic [CW-1:0]   load_val;
  logic            counting;

  assign scl_seen      = sync_q[SYNC-1];
  assign load_val      = (reload_val == '0) ? ONE : reload_val;
  assign counting      = (st == S_LOW) || (st == S_HIGH);
  assign scl_drive_low = (st == S_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], scl_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      high_done <= 1'b0;
      low_done  <= 1'b0;
    end else begin
      high_done <= 1'b0;
      low_done  <= 1'b0;
      if (!enable) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st  <= S_LOW;
            cnt <= load_val;
          end
          S_LOW: begin
            if (cnt == '0) begin
              st       <= S_WAIT;
              low_done <= 1'b1;
            end else if (tick) begin
              cnt <= cnt - ONE;
            end
          end
          S_WAIT: begin
            if (scl_seen) begin
              st  <= S_HIGH;
              cnt <= load_val;
            end
          end
          default: begin
            if (cnt == '0) begin
              st        <= S_LOW;
              cnt       <= load_val;
              high_done <= 1'b1;
            end else if (tick) begin
              cnt <= cnt - ONE;
            end
          end
        endcase
      end
    end
  end

  assert_nonzero_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && enable) |=> (cnt != '0));

  assert_wait_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !scl_seen && enable) |=> ($stable(cnt) && !scl_drive_low && !high_done));

  assert_reload_on_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && scl_seen && enable) |=> (st == S_HIGH && cnt == $past(load_val)));

  assert_tick_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && enable && cnt != '0 && !tick) |=> $stable(cnt));

  assert_disable_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !high_done && !low_done));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done || low_done) |=> !(high_done || low_done));

  assert_exclusive_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(high_done && low_done));

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       enable = 1'b0;
  logic [6:0] reload_val = 7'd3;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, high_done, low_done;

  int n_checks = 0;
  int n_fail = 0;
  int pulse_err = 0;
  bit prev_pulse = 1'b0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  assign scl_in = !(scl_drive_low || slave_hold);

  scl_clock_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .reload_val(reload_val), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .high_done(high_done), .low_done(low_done)
  );

  // R9 monitor: single-cycle, mutually exclusive pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (high_done && low_done) pulse_err++;
      if (prev_pulse && (high_done || low_done)) pulse_err++;
    end
    prev_pulse = high_done || low_done;
  end

  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{3, 0}, '{3, 5}, '{1, 0}, '{0, 0}, '{10, 12}, '{127, 3}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    slave_hold = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_vector(input int r, input int hold);
    int low_cnt, high_cnt, guard;
    bit hd_during_hold;
    reload_val = 7'(r);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b1, "R2", int'(scl_drive_low), 1);
    if (hold > 0) slave_hold = 1'b1;
    low_cnt = 0;
    guard = 0;
    while (scl_drive_low && guard < 1000) begin
      low_cnt++;
      guard++;
      @(negedge clk);
    end
    check(low_cnt == eff(r) + 1, (r == 0) ? "R7" : "R3", low_cnt, eff(r) + 1);
    check(low_done == 1'b1, "R3", int'(low_done), 1);
    if (hold > 0) begin
      hd_during_hold = 1'b0;
      for (int i = 0; i < hold; i++) begin
        if (high_done || scl_drive_low) hd_during_hold = 1'b1;
        @(negedge clk);
      end
      check(!hd_during_hold && !scl_drive_low, "R4", int'(hd_during_hold), 0);
      @(posedge clk);
      #1 slave_hold = 1'b0;
      @(negedge clk);
    end
    high_cnt = 0;
    guard = 0;
    while (!scl_drive_low && guard < 1000) begin
      if (scl_in) high_cnt++;
      guard++;
      @(negedge clk);
    end
    check(high_cnt == eff(r) + 4, "R5", high_cnt, eff(r) + 4);
    check(high_done == 1'b1, "R5", int'(high_done), 1);
    stop_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !high_done && !low_done, "R1", int'(scl_drive_low), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_drive_low && !high_done && !low_done, "R1", int'(scl_drive_low), 0);

    for (int v = 0; v < NV; v++) run_vector(VEC[v][0], VEC[v][1]);

    begin : tick_test
      bit any_done;
      reload_val = 7'd2;
      tick = 1'b0;
      @(negedge clk);
      enable = 1'b1;
      any_done = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!scl_drive_low || low_done) any_done = 1'b1;
      end
      check(!any_done, "R6", int'(any_done), 0);
      tick = 1'b1;
      repeat (3) @(negedge clk);
      check(low_done == 1'b1 && !scl_drive_low, "R6", int'(low_done), 1);
      stop_run();
    end

    begin : disable_test
      reload_val = 7'd6;
      @(negedge clk);
      enable = 1'b1;
      repeat (3) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check(scl_drive_low == 1'b0, "R8", int'(scl_drive_low), 0);
      done_flag = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (high_done || low_done || scl_drive_low) done_flag = 1'b1;
        @(negedge clk);
      end
      check(!done_flag, "R8", int'(done_flag), 0);
    end

    check(pulse_err == 0, "R9", pulse_err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule